// File: doc/BRIEF.md
# Bus Adapter Status Register

This block holds the control and status word of a bus adapter and turns the interrupt programming in that word into level masks. Software writes the 18-bit register and reads it back. Four error flags and a power-fail flag are set by hardware events outside the block. Software clears the error flags by writing ones to them. Any write to the register clears the power-fail flag. The control fields are loaded from each write.

Two 3-bit fields select the interrupt levels used for high-priority and low-priority device requests. Each field is decoded into an 8-bit one-hot mask for the interrupt mapper next to this block. Writing the initialize bit sends a one-cycle pulse to the bus and clears both level fields. Level programming and initialization therefore never take effect in the same write.

A select input chooses between the status register and the maintenance register next to it. The maintenance register reads as zero and ignores writes.

Top module: `astat_top`

## Requirements
- R1: After reset the status word, both masks and the initialize pulse are all zero.
- R2: Error flags sit at bits 17 (timeout), 16 (bad memory), 15 (parity) and 14 (nonexistent device). A status write with a 1 in a flag's position clears that flag. A 0 in that position leaves the flag unchanged.
- R3: err_set[3:0] sets bits 17..14 in that order, and pwr_set sets bit 13, each in the cycle after it is asserted. A set in the same cycle as a clearing write wins, and the flag stays 1.
- R4: The power-fail flag at bit 13 is cleared by every status write, whatever the data.
- R5: Every status write loads transfer-disable (bit 7), initialize (bit 6), high level code (bits 5:3) and low level code (bits 2:0) from the write data.
- R6: When a status write has bit 6 set, the stored initialize bit and both level codes become zero. Transfer-disable is still loaded.
- R7: A level code of 0 gives an all-zero mask. A code k from 1 to 7 gives a mask with only bit k set. hi_mask follows bits 5:3 and lo_mask follows bits 2:0.
- R8: init_pulse is high for exactly the one cycle after a status write with bit 6 set, and low otherwise.
- R9: With reg_sel = 1 (maintenance register), rd_data is zero and writes change no state.
- R10: Bits 12:8 of the status word always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the status register, 1 selects the maintenance register |
| wr_data | input | 18 | Write data |
| err_set | input | 4 | Error flag set events (timeout, bad memory, parity, nonexistent device) |
| pwr_set | input | 1 | Power-fail set event |
| rd_data | output | 18 | Read data for the selected register |
| hi_mask | output | 8 | One-hot high-priority interrupt level |
| lo_mask | output | 8 | One-hot low-priority interrupt level |
| xfer_dis | output | 1 | Transfer-disable control bit |
| init_pulse | output | 1 | One-cycle bus initialize pulse |

## Verification
The hardest cases to reach are collisions: a hardware set event in the same cycle as a write that clears the same flag, and a write that carries both initialize and nonzero level codes. The stimulus table arranges these collisions directly. It raises err_set on a flag the same write clears, and raises pwr_set during a write. It writes initialize together with level codes 7 and 1. A following read shows which value survived. A final directed sweep steps both level codes through all eight values.

// File: rtl/astat_pkg.sv
package astat_pkg;
   localparam int unsigned REG_W     = 18;
   localparam int unsigned PI_CODE_W = 3;
   localparam int unsigned PI_LVLS   = 1 << PI_CODE_W;
   localparam int unsigned LO_LSB    = 0;
   localparam int unsigned HI_LSB    = LO_LSB + PI_CODE_W;
   localparam int unsigned INIT_BIT  = HI_LSB + PI_CODE_W;
   localparam int unsigned XDIS_BIT  = INIT_BIT + 1;
   localparam int unsigned PWR_BIT   = 13;
   localparam int unsigned ERR_LSB   = 14;
   localparam int unsigned ERR_N     = 4;

   typedef struct packed {
      logic                 xdis;
      logic                 init;
      logic [PI_CODE_W-1:0] hi;
      logic [PI_CODE_W-1:0] lo;
   } ctl_t;
endpackage

// File: rtl/astat_pidec.sv
module astat_pidec #(
   parameter int unsigned CODE_W = 3,
   localparam int unsigned LVLS  = 1 << CODE_W
) (
   input  logic [CODE_W-1:0] code,
   output logic [LVLS-1:0]   mask
);
   initial begin
      if (CODE_W < 1 || CODE_W > 6) $error("astat_pidec: CODE_W out of range");
   end

   for (genvar k = 0; k < LVLS; k++) begin : g_lvl
      if (k == 0) begin : g_none
         assign mask[k] = 1'b0;
      end else begin : g_hit
         assign mask[k] = (code == CODE_W'(k));
      end
   end
endmodule

// File: rtl/astat_flagbit.sv
module astat_flagbit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_i | (q & ~clr_i);
   end
endmodule

// File: rtl/astat_ctlreg.sv
module astat_ctlreg
   import astat_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ld,
   input  ctl_t din,
   output ctl_t q,
   output logic init_pulse
);
   ctl_t nxt;

   always_comb begin
      nxt = q;
      if (ld) begin
         nxt = din;
         if (din.init) begin
            nxt.init = 1'b0;
            nxt.hi   = '0;
            nxt.lo   = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q          <= '0;
         init_pulse <= 1'b0;
      end else begin
         q          <= nxt;
         init_pulse <= ld & din.init;
      end
   end
endmodule

// File: rtl/astat_top.sv
module astat_top
   import astat_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 reg_sel,
   input  logic [REG_W-1:0]     wr_data,
   input  logic [ERR_N-1:0]     err_set,
   input  logic                 pwr_set,
   output logic [REG_W-1:0]     rd_data,
   output logic [PI_LVLS-1:0]   hi_mask,
   output logic [PI_LVLS-1:0]   lo_mask,
   output logic                 xfer_dis,
   output logic                 init_pulse
);
   initial begin
      if (ERR_LSB + ERR_N > REG_W) $error("astat_top: error field past word");
      if (PWR_BIT >= ERR_LSB || PWR_BIT <= XDIS_BIT) $error("astat_top: power bit overlaps");
   end

   logic             wr_stat;
   logic [ERR_N-1:0] err_q;
   logic             pwr_q;
   ctl_t             ctl_q;
   ctl_t             ctl_din;
   logic [REG_W-1:0] stat_q;

   assign wr_stat = wr_en & ~reg_sel;

   for (genvar i = 0; i < ERR_N; i++) begin : g_err
      astat_flagbit u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (err_set[i]),
         .clr_i (wr_stat & wr_data[ERR_LSB+i]),
         .q     (err_q[i])
      );
   end

   astat_flagbit u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (pwr_set),
      .clr_i (wr_stat),
      .q     (pwr_q)
   );

   assign ctl_din.xdis = wr_data[XDIS_BIT];
   assign ctl_din.init = wr_data[INIT_BIT];
   assign ctl_din.hi   = wr_data[HI_LSB +: PI_CODE_W];
   assign ctl_din.lo   = wr_data[LO_LSB +: PI_CODE_W];

   astat_ctlreg u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld         (wr_stat),
      .din        (ctl_din),
      .q          (ctl_q),
      .init_pulse (init_pulse)
   );

   always_comb begin
      stat_q                          = '0;
      stat_q[ERR_LSB +: ERR_N]        = err_q;
      stat_q[PWR_BIT]                 = pwr_q;
      stat_q[XDIS_BIT]                = ctl_q.xdis;
      stat_q[INIT_BIT]                = ctl_q.init;
      stat_q[HI_LSB +: PI_CODE_W]     = ctl_q.hi;
      stat_q[LO_LSB +: PI_CODE_W]     = ctl_q.lo;
   end

   assign rd_data  = reg_sel ? '0 : stat_q;
   assign xfer_dis = ctl_q.xdis;

   astat_pidec #(.CODE_W(PI_CODE_W)) u_hidec (.code(ctl_q.hi), .mask(hi_mask));
   astat_pidec #(.CODE_W(PI_CODE_W)) u_lodec (.code(ctl_q.lo), .mask(lo_mask));
endmodule

// File: rtl/astat_chk.sv
module astat_chk
   import astat_pkg::*;
(
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               reg_sel,
   input logic [REG_W-1:0]   wr_data,
   input logic [ERR_N-1:0]   err_set,
   input logic               pwr_set,
   input logic [REG_W-1:0]   stat_q,
   input logic [REG_W-1:0]   rd_data,
   input logic [PI_LVLS-1:0] hi_mask,
   input logic [PI_LVLS-1:0] lo_mask,
   input logic               init_pulse
);
   // R3
   err_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set != '0) |=> ((stat_q[ERR_LSB +: ERR_N] & $past(err_set)) == $past(err_set)));
   // R4
   pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !reg_sel && !pwr_set) |=> !stat_q[PWR_BIT]);
   // R6
   init_clears_pi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !reg_sel && wr_data[INIT_BIT]) |=> (hi_mask == '0 && lo_mask == '0));
   // R7
   mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hi_mask) && $onehot0(lo_mask) && !hi_mask[0] && !lo_mask[0]);
   // R8
   init_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_pulse |-> $past(wr_en && !reg_sel && wr_data[INIT_BIT]));
   // R9
   maint_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (rd_data == '0));
   // R10
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_q[PWR_BIT-1:XDIS_BIT+1] == '0);
endmodule

bind astat_top astat_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .reg_sel    (reg_sel),
   .wr_data    (wr_data),
   .err_set    (err_set),
   .pwr_set    (pwr_set),
   .stat_q     (stat_q),
   .rd_data    (rd_data),
   .hi_mask    (hi_mask),
   .lo_mask    (lo_mask),
   .init_pulse (init_pulse)
);

// File: tb/sim_astat_top.sv
`timescale 1ns/1ps
module sim_astat_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        reg_sel = 1'b0;
   logic [17:0] wr_data = '0;
   logic [3:0]  err_set = '0;
   logic        pwr_set = 1'b0;
   logic [17:0] rd_data;
   logic [7:0]  hi_mask, lo_mask;
   logic        xfer_dis, init_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   astat_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
      .wr_data(wr_data), .err_set(err_set), .pwr_set(pwr_set),
      .rd_data(rd_data), .hi_mask(hi_mask), .lo_mask(lo_mask),
      .xfer_dis(xfer_dis), .init_pulse(init_pulse)
   );

   typedef struct packed {
      logic        we;
      logic        sel;
      logic [17:0] wd;
      logic [3:0]  es;
      logic        ps;
      logic [17:0] exp_rd;
      logic        exp_pulse;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      // R3: raise all error flags and power fail with no write
      '{we:1'b0, sel:1'b0, wd:18'h00000, es:4'hF, ps:1'b1, exp_rd:18'h3E000, exp_pulse:1'b0},
      // R4 R5: write levels hi=5 lo=2, power flag cleared, errors kept
      '{we:1'b1, sel:1'b0, wd:18'h0002A, es:4'h0, ps:1'b0, exp_rd:18'h3C02A, exp_pulse:1'b0},
      // R2: clear timeout and parity only
      '{we:1'b1, sel:1'b0, wd:18'h2802A, es:4'h0, ps:1'b0, exp_rd:18'h1402A, exp_pulse:1'b0},
      // R3: clear bits 16 and 14 while bit 16 is set again
      '{we:1'b1, sel:1'b0, wd:18'h14000, es:4'h4, ps:1'b0, exp_rd:18'h10000, exp_pulse:1'b0},
      // R9: maintenance write of all ones is ignored, reads zero
      '{we:1'b1, sel:1'b1, wd:18'h3FFFF, es:4'h0, ps:1'b0, exp_rd:18'h00000, exp_pulse:1'b0},
      // R9: status unchanged afterwards
      '{we:1'b0, sel:1'b0, wd:18'h00000, es:4'h0, ps:1'b0, exp_rd:18'h10000, exp_pulse:1'b0},
      // R6 R8: init with levels 7/1 and transfer-disable
      '{we:1'b1, sel:1'b0, wd:18'h000F9, es:4'h0, ps:1'b0, exp_rd:18'h10080, exp_pulse:1'b1},
      // R5 R7: hi=1 lo=7
      '{we:1'b1, sel:1'b0, wd:18'h0008F, es:4'h0, ps:1'b0, exp_rd:18'h1008F, exp_pulse:1'b0},
      // R3 R4: power set during a write wins
      '{we:1'b1, sel:1'b0, wd:18'h00000, es:4'h0, ps:1'b1, exp_rd:18'h12000, exp_pulse:1'b0},
      // R2 R4: clear bad memory, power cleared, hi=7 lo=7
      '{we:1'b1, sel:1'b0, wd:18'h1003F, es:4'h0, ps:1'b0, exp_rd:18'h0003F, exp_pulse:1'b0},
      // R6 R10: all-ones write: only transfer-disable survives, bits 12:8 zero
      '{we:1'b1, sel:1'b0, wd:18'h3FFFF, es:4'h0, ps:1'b0, exp_rd:18'h00080, exp_pulse:1'b1},
      // R8: pulse lasts a single cycle
      '{we:1'b0, sel:1'b0, wd:18'h00000, es:4'h0, ps:1'b0, exp_rd:18'h00080, exp_pulse:1'b0}
   };

   function automatic logic [7:0] exp_mask(input logic [2:0] code);
      return (code == 3'd0) ? 8'h00 : (8'h01 << code);
   endfunction

   task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %05h expected %05h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic apply(input logic we, input logic sel, input logic [17:0] wd,
                        input logic [3:0] es, input logic ps);
      @(negedge clk);
      wr_en = we; reg_sel = sel; wr_data = wd; err_set = es; pwr_set = ps;
      @(posedge clk);
      #2;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      logic [17:0] last_stat;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 rd_data", rd_data, 18'h0);
      chk("R1 hi_mask", 18'(hi_mask), 18'h0);
      chk("R1 lo_mask", 18'(lo_mask), 18'h0);
      chk("R1 init_pulse", 18'(init_pulse), 18'h0);

      last_stat = '0;
      for (int i = 0; i < NV; i++) begin
         apply(VECS[i].we, VECS[i].sel, VECS[i].wd, VECS[i].es, VECS[i].ps);
         if (!VECS[i].sel) last_stat = VECS[i].exp_rd;
         chk(VECS[i].sel ? "R9 rd_data" : "R2-R6 rd_data", rd_data, VECS[i].exp_rd);
         chk("R7 hi_mask", 18'(hi_mask), 18'(exp_mask(last_stat[5:3])));
         chk("R7 lo_mask", 18'(lo_mask), 18'(exp_mask(last_stat[2:0])));
         chk("R8 init_pulse", 18'(init_pulse), 18'(VECS[i].exp_pulse));
      end

      // R7: sweep every level code, R5 xfer_dis loaded each time
      for (int k = 0; k < 8; k++) begin
         apply(1'b1, 1'b0, 18'((k[0] << 7) | ((7 - k) << 3) | k), 4'h0, 1'b0);
         chk("R7 lo sweep", 18'(lo_mask), 18'(exp_mask(3'(k))));
         chk("R7 hi sweep", 18'(hi_mask), 18'(exp_mask(3'(7 - k))));
         chk("R5 xfer_dis", 18'(xfer_dis), 18'(k[0]));
      end

      // R1: reset again clears everything
      apply(1'b0, 1'b0, 18'h0, 4'hF, 1'b1);
      @(negedge clk); rst_n = 1'b0; err_set = '0; pwr_set = 1'b0;
      @(posedge clk); #2;
      rst_n = 1'b1;
      chk("R1 rd_data after reset", rd_data, 18'h0);

      done = 1;
      finish_run();
   end
endmodule